// File: doc/BRIEF.md
# Multi-Core Reset and Power Request Controller

This block sits on a simple 32-bit register bus and governs a four-core processor cluster. It holds a word-indexed register file of eighteen 32-bit entries: a control word at index 0, two boot-mode words at indices 1 and 7, a reset-status word at 2, interrupt status and mask words at 5 and 6, plain storage at 3 and 4, and ten general-purpose words at indices 8 to 17. The word index is the byte address shifted right by two. Only aligned 32-bit accesses are meaningful.

A write to the control word does not just store data. The block compares the written value with the stored one, and only bits that differ trigger actions. When the enable bit of core 1, 2 or 3 flips, that core gets a power-on request, with an entry address and a context word taken from a pair of general-purpose words, or a power-off request. That flip also cancels any reset request for the same core. Any other changed core reset bit produces a one-cycle reset pulse to that core. Reset bits and the two peripheral soft-reset bits always read back as zero afterwards. Core 0 has no enable bit and can only be reset.

All requests leave the block as single-cycle registered pulses, in the cycle after the bus write. Read data is registered and appears one cycle after the read enable.

Top module: `rst_ctl`

## Requirements
- R1: After reset, every word reads 0, except the control word (index 0), which reads 0x521, the reset-status word (index 2), which reads 0x1, and the interrupt-mask word (index 6), which reads 0x1F.
- R2: A write at index 1 to 17 stores the value unchanged. Read data appears on `bus_rdata` one cycle after `bus_rd`. A read issued in the same cycle as a write to the same index returns the old value.
- R3: A read at an index of 18 or more returns 0, and a write at such an index changes no register.
- R4: A control write that changes the enable bit of core c (bit 21+c, c = 1..3) from 0 to 1 raises `core_on_req[c]` for exactly one cycle, in the cycle after the write. In that cycle, `core_entry` slice c holds the word at index 8+2c and `core_ctx` slice c holds the word at index 9+2c.
- R5: A control write that changes the enable bit of core c from 1 to 0 raises `core_off_req[c]` for exactly one cycle, in the cycle after the write.
- R6: When the enable bit of core c changes, that core's reset bit (bit 13+c) is stored as 0 and no `core_rst[c]` pulse is issued, even if the written reset bit is 1.
- R7: Any other changed core reset bit (bit 13+c, c = 0..3) raises `core_rst[c]` for one cycle, in the cycle after the write, and the bit reads back as 0.
- R8: A changed bit 3 of the control word pulses `periph_rst[0]`, and a changed bit 12 pulses `periph_rst[1]`. Both bits read back as 0.
- R9: All other control bits, including bit 21, are stored as written. A control write that leaves every enable and reset bit unchanged issues no request.
- R10: `core_on_req[0]` and `core_off_req[0]` never rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bus_addr | input | 12 | Byte address; bits 11:2 give the word index |
| bus_wr | input | 1 | Write enable |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read enable |
| bus_rdata | output | 32 | Registered read data, valid one cycle after bus_rd |
| core_on_req | output | 4 | Per-core power-on request pulse (bit 0 unused) |
| core_off_req | output | 4 | Per-core power-off request pulse (bit 0 unused) |
| core_entry | output | 128 | Per-core entry address, 32 bits per core, valid with core_on_req |
| core_ctx | output | 128 | Per-core context word, 32 bits per core, valid with core_on_req |
| core_rst | output | 4 | Per-core reset pulse |
| periph_rst | output | 2 | Peripheral soft-reset pulses |

## Verification
The assertions check, on every cycle, the invariants that tie the outputs to the stored control word. A power-on pulse only appears while the stored enable is 1, and a power-off pulse only while it is 0. A reset pulse never coincides with a power request for the same core. The self-clearing bits are never stored as 1. Pulses never last longer than one cycle, and out-of-range reads return zero. Some behaviour can only be shown by the bench's scenarios, because it depends on what was written: which pulse follows a given old/new pair, that the entry and context words come from the right general-purpose pair, that a same-cycle read returns the old data, and that out-of-range writes leave every word intact.

// File: rtl/rst_ctl_pkg.sv
package rst_ctl_pkg;
  localparam int DATA_W   = 32;
  localparam int NWORDS   = 18;
  localparam int NCORES   = 4;
  localparam int NPERIPH  = 2;
  localparam int WIDX_W   = $clog2(NWORDS);

  localparam int IDX_CTRL   = 0;
  localparam int IDX_STATUS = 2;
  localparam int IDX_IMASK  = 6;
  localparam int IDX_GPR0   = 8;

  localparam int EN_BASE    = 21;  // enable of core c sits at EN_BASE + c
  localparam int CRST_BASE  = 13;  // reset of core c sits at CRST_BASE + c
  localparam int PRST_LO    = 3;
  localparam int PRST_HI    = 12;

  localparam logic [DATA_W-1:0] CTRL_INIT   = 32'h0000_0521;
  localparam logic [DATA_W-1:0] STATUS_INIT = 32'h0000_0001;
  localparam logic [DATA_W-1:0] IMASK_INIT  = 32'h0000_001F;

  function automatic int en_bit(input int c);
    return EN_BASE + c;
  endfunction

  function automatic int crst_bit(input int c);
    return CRST_BASE + c;
  endfunction

  function automatic int entry_idx(input int c);
    return IDX_GPR0 + 2 * c;
  endfunction

  function automatic int ctx_idx(input int c);
    return IDX_GPR0 + 2 * c + 1;
  endfunction

  function automatic logic [DATA_W-1:0] init_word(input int i);
    case (i)
      IDX_CTRL:   return CTRL_INIT;
      IDX_STATUS: return STATUS_INIT;
      IDX_IMASK:  return IMASK_INIT;
      default:    return '0;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] self_clear_mask();
    logic [DATA_W-1:0] m;
    m = '0;
    for (int c = 0; c < NCORES; c++) m[crst_bit(c)] = 1'b1;
    m[PRST_LO] = 1'b1;
    m[PRST_HI] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/rst_ctl_regfile.sv
module rst_ctl_regfile
  import rst_ctl_pkg::*;
(
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [WIDX_W-1:0]              wr_idx,
  input  logic [DATA_W-1:0]              wr_data,
  input  logic                           rd_en,
  input  logic                           rd_ok,
  input  logic [WIDX_W-1:0]              rd_idx,
  output logic [DATA_W-1:0]              rd_data,
  output logic [NWORDS-1:0][DATA_W-1:0]  words
);
  logic [NWORDS-1:0][DATA_W-1:0] words_q, words_d;
  logic [DATA_W-1:0]             rdata_q, rdata_d;

  always_comb begin
    words_d = words_q;
    if (wr_en) words_d[wr_idx] = wr_data;
  end

  always_comb begin
    rdata_d = rdata_q;
    if (rd_en) rdata_d = rd_ok ? words_q[rd_idx] : '0;
  end

  for (genvar i = 0; i < NWORDS; i++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) words_q[i] <= init_word(i);
      else if (wr_en) words_q[i] <= words_d[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else if (rd_en) rdata_q <= rdata_d;
  end

  assign rd_data = rdata_q;
  assign words   = words_q;

  // R3
  oob_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !rd_ok) |=> (rd_data == '0));
endmodule

// File: rtl/rst_ctl_decode.sv
module rst_ctl_decode
  import rst_ctl_pkg::*;
(
  input  logic [DATA_W-1:0]  old_word,
  input  logic [DATA_W-1:0]  new_word,
  output logic [DATA_W-1:0]  keep_word,
  output logic [NCORES-1:0]  on_hit,
  output logic [NCORES-1:0]  off_hit,
  output logic [NCORES-1:0]  crst_hit,
  output logic [NPERIPH-1:0] prst_hit
);
  logic [DATA_W-1:0] flip;

  always_comb begin
    flip      = old_word ^ new_word;
    keep_word = new_word;
    on_hit    = '0;
    off_hit   = '0;
    crst_hit  = '0;
    prst_hit  = '0;
    for (int c = 1; c < NCORES; c++) begin
      if (flip[en_bit(c)]) begin
        on_hit[c]               = new_word[en_bit(c)];
        off_hit[c]              = !new_word[en_bit(c)];
        keep_word[crst_bit(c)]  = 1'b0;
        flip[crst_bit(c)]       = 1'b0;
      end
    end
    for (int c = 0; c < NCORES; c++) begin
      if (flip[crst_bit(c)]) begin
        crst_hit[c]            = 1'b1;
        keep_word[crst_bit(c)] = 1'b0;
      end
    end
    if (flip[PRST_LO]) begin
      prst_hit[0]        = 1'b1;
      keep_word[PRST_LO] = 1'b0;
    end
    if (flip[PRST_HI]) begin
      prst_hit[1]        = 1'b1;
      keep_word[PRST_HI] = 1'b0;
    end
  end
endmodule

// File: rtl/rst_ctl_core_port.sv
module rst_ctl_core_port
  import rst_ctl_pkg::*;
#(
  parameter bit HAS_POWER = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic              on_d,
  input  logic              off_d,
  input  logic              rst_d,
  input  logic [DATA_W-1:0] entry_d,
  input  logic [DATA_W-1:0] ctx_d,
  output logic              on_q,
  output logic              off_q,
  output logic              rst_q,
  output logic [DATA_W-1:0] entry_q,
  output logic [DATA_W-1:0] ctx_q
);
  localparam logic PWR = HAS_POWER;

  logic              on_n, off_n, rst_nx;
  logic [DATA_W-1:0] entry_n, ctx_n;

  always_comb begin
    on_n    = fire && on_d && PWR;
    off_n   = fire && off_d && PWR;
    rst_nx  = fire && rst_d;
    entry_n = on_n ? entry_d : entry_q;
    ctx_n   = on_n ? ctx_d : ctx_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_q  <= 1'b0;
      off_q <= 1'b0;
      rst_q <= 1'b0;
    end else begin
      on_q  <= on_n;
      off_q <= off_n;
      rst_q <= rst_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      entry_q <= '0;
      ctx_q   <= '0;
    end else if (on_n) begin
      entry_q <= entry_n;
      ctx_q   <= ctx_n;
    end
  end

  // R4
  on_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    on_q |=> !on_q);
  // R5
  off_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    off_q |=> !off_q);
endmodule

// File: rtl/rst_ctl.sv
module rst_ctl
  import rst_ctl_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic                        bus_wr,
  input  logic [DATA_W-1:0]           bus_wdata,
  input  logic                        bus_rd,
  output logic [DATA_W-1:0]           bus_rdata,
  output logic [NCORES-1:0]           core_on_req,
  output logic [NCORES-1:0]           core_off_req,
  output logic [NCORES*DATA_W-1:0]    core_entry,
  output logic [NCORES*DATA_W-1:0]    core_ctx,
  output logic [NCORES-1:0]           core_rst,
  output logic [NPERIPH-1:0]          periph_rst
);
  localparam int IDX_W = ADDR_W - 2;
  localparam logic [DATA_W-1:0] SC_MASK = self_clear_mask();

  logic [IDX_W-1:0]              idx_full;
  logic                          idx_ok;
  logic [WIDX_W-1:0]             idx;
  logic                          ctrl_wr;
  logic [DATA_W-1:0]             store_data;
  logic [NWORDS-1:0][DATA_W-1:0] words;
  logic [DATA_W-1:0]             keep_word;
  logic [NCORES-1:0]             on_hit, off_hit, crst_hit;
  logic [NPERIPH-1:0]            prst_hit;
  logic [NPERIPH-1:0]            prst_q, prst_n;

  assign idx_full   = bus_addr[ADDR_W-1:2];
  assign idx_ok     = idx_full < IDX_W'(NWORDS);
  assign idx        = idx_full[WIDX_W-1:0];
  assign ctrl_wr    = bus_wr && idx_ok && (idx == WIDX_W'(IDX_CTRL));
  assign store_data = ctrl_wr ? keep_word : bus_wdata;

  rst_ctl_regfile u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (bus_wr && idx_ok),
    .wr_idx  (idx),
    .wr_data (store_data),
    .rd_en   (bus_rd),
    .rd_ok   (idx_ok),
    .rd_idx  (idx),
    .rd_data (bus_rdata),
    .words   (words)
  );

  rst_ctl_decode u_dec (
    .old_word  (words[IDX_CTRL]),
    .new_word  (bus_wdata),
    .keep_word (keep_word),
    .on_hit    (on_hit),
    .off_hit   (off_hit),
    .crst_hit  (crst_hit),
    .prst_hit  (prst_hit)
  );

  for (genvar c = 0; c < NCORES; c++) begin : g_core
    localparam bit PWR = (c != 0);
    localparam int EI  = PWR ? entry_idx(c) : IDX_CTRL;
    localparam int CI  = PWR ? ctx_idx(c) : IDX_CTRL;

    rst_ctl_core_port #(.HAS_POWER(PWR)) u_port (
      .clk     (clk),
      .rst_n   (rst_n),
      .fire    (ctrl_wr),
      .on_d    (on_hit[c]),
      .off_d   (off_hit[c]),
      .rst_d   (crst_hit[c]),
      .entry_d (words[EI]),
      .ctx_d   (words[CI]),
      .on_q    (core_on_req[c]),
      .off_q   (core_off_req[c]),
      .rst_q   (core_rst[c]),
      .entry_q (core_entry[c*DATA_W +: DATA_W]),
      .ctx_q   (core_ctx[c*DATA_W +: DATA_W])
    );

    if (PWR) begin : g_pwr_chk
      // R4
      on_sees_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_on_req[c] |-> words[IDX_CTRL][en_bit(c)]);
      // R5
      off_sees_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_off_req[c] |-> !words[IDX_CTRL][en_bit(c)]);
    end

    // R6
    rst_not_with_power_chk: assert property (@(posedge clk) disable iff (!rst_n)
      core_rst[c] |-> !(core_on_req[c] || core_off_req[c]));
  end

  always_comb begin
    prst_n = ctrl_wr ? prst_hit : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prst_q <= '0;
    else prst_q <= prst_n;
  end

  assign periph_rst = prst_q;

  // R7
  self_clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (words[IDX_CTRL] & SC_MASK) == '0);
  // R8
  periph_pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|periph_rst) |=> ((periph_rst & $past(periph_rst)) == '0));
endmodule

// File: tb/sim_rst_ctl.sv
module sim_rst_ctl;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [11:0]  bus_addr = '0;
  logic         bus_wr = 1'b0;
  logic [31:0]  bus_wdata = '0;
  logic         bus_rd = 1'b0;
  logic [31:0]  bus_rdata;
  logic [3:0]   core_on_req, core_off_req, core_rst;
  logic [127:0] core_entry, core_ctx;
  logic [1:0]   periph_rst;

  int checks = 0;
  int errors = 0;

  logic [31:0] m [18];
  logic [3:0]  e_on, e_off, e_rst;
  logic [1:0]  e_prst;

  always #4 clk = ~clk;

  rst_ctl u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .core_on_req(core_on_req), .core_off_req(core_off_req),
    .core_entry(core_entry), .core_ctx(core_ctx), .core_rst(core_rst),
    .periph_rst(periph_rst)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  function automatic void model_reset();
    for (int i = 0; i < 18; i++) m[i] = 32'h0;
    m[0] = 32'h521;
    m[2] = 32'h1;
    m[6] = 32'h1F;
  endfunction

  // Expected effect of a control write, from R4..R9
  function automatic void model_ctrl(input logic [31:0] nv);
    logic [31:0] ch, sv;
    ch = m[0] ^ nv;
    sv = nv;
    e_on = '0; e_off = '0; e_rst = '0; e_prst = '0;
    for (int c = 1; c < 4; c++) begin
      if (ch[21+c]) begin
        if (nv[21+c]) e_on[c] = 1'b1;
        else e_off[c] = 1'b1;
        sv[13+c] = 1'b0;
        ch[13+c] = 1'b0;
      end
    end
    for (int c = 0; c < 4; c++) begin
      if (ch[13+c]) begin
        e_rst[c] = 1'b1;
        sv[13+c] = 1'b0;
      end
    end
    if (ch[3])  begin e_prst[0] = 1'b1; sv[3]  = 1'b0; end
    if (ch[12]) begin e_prst[1] = 1'b1; sv[12] = 1'b0; end
    m[0] = sv;
  endfunction

  task automatic do_write(input int idx, input logic [31:0] data, input string req);
    logic [31:0] ent [4];
    logic [31:0] ctx [4];
    for (int c = 1; c < 4; c++) begin
      ent[c] = m[8+2*c];
      ctx[c] = m[9+2*c];
    end
    @(negedge clk);
    bus_addr  = {idx[9:0], 2'b00};
    bus_wr    = 1'b1;
    bus_wdata = data;
    e_on = '0; e_off = '0; e_rst = '0; e_prst = '0;
    if (idx == 0) model_ctrl(data);
    else if (idx < 18) m[idx] = data;
    @(negedge clk);
    bus_wr = 1'b0;
    check({req, " on pulse"},    {28'h0, core_on_req},  {28'h0, e_on});
    check({req, " off pulse"},   {28'h0, core_off_req}, {28'h0, e_off});
    check({req, " core reset"},  {28'h0, core_rst},     {28'h0, e_rst});
    check({req, " periph reset"},{30'h0, periph_rst},   {30'h0, e_prst});
    for (int c = 1; c < 4; c++) begin
      if (e_on[c]) begin
        check({req, " entry R4"}, core_entry[c*32 +: 32], ent[c]);
        check({req, " ctx R4"},   core_ctx[c*32 +: 32],   ctx[c]);
      end
    end
    @(negedge clk);
    check({req, " pulses drop R4 R5 R7"},
          {18'h0, core_on_req, core_off_req, core_rst, periph_rst}, 32'h0);
  endtask

  task automatic do_read(input int idx, input string req);
    logic [31:0] exp;
    @(negedge clk);
    bus_addr = {idx[9:0], 2'b00};
    bus_rd   = 1'b1;
    exp = (idx < 18) ? m[idx] : 32'h0;
    @(negedge clk);
    bus_rd = 1'b0;
    check(req, bus_rdata, exp);
  endtask

  task automatic do_rw(input int idx, input logic [31:0] data);
    logic [31:0] exp;
    @(negedge clk);
    bus_addr  = {idx[9:0], 2'b00};
    bus_rd    = 1'b1;
    bus_wr    = 1'b1;
    bus_wdata = data;
    exp = m[idx];
    m[idx] = data;
    @(negedge clk);
    bus_rd = 1'b0;
    bus_wr = 1'b0;
    check("R2 same-cycle read returns old", bus_rdata, exp);
  endtask

  task automatic read_all(input string req);
    for (int i = 0; i < 18; i++) do_read(i, req);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'h1234_5EED));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset values
    read_all("R1 reset value");
    check("R1 idle outputs",
          {18'h0, core_on_req, core_off_req, core_rst, periph_rst}, 32'h0);

    // R2 plain storage and same-cycle read
    for (int i = 8; i < 18; i++) do_write(i, 32'hA000_0000 + i * 32'h111, "R2 gpr write");
    do_write(3, 32'hDEAD_BEEF, "R2 plain write");
    do_read(3, "R2 readback");
    do_rw(4, 32'h1357_9BDF);
    do_read(4, "R2 readback after rw");

    // R3 out-of-range
    do_read(18, "R3 oob read 18");
    do_read(1023, "R3 oob read 1023");
    do_write(18, 32'hFFFF_FFFF, "R3 oob write");
    do_write(600, 32'h5555_AAAA, "R3 oob write");
    read_all("R3 no register changed");

    // R4 power-on core 1, R10 bit 21 is plain storage
    v = m[0] | (32'h1 << 22) | (32'h1 << 21);
    do_write(0, v, "R4 R10 enable core1");
    do_read(0, "R9 R10 ctrl readback");
    // R4 core 2 with reset bit also set: R6 cancels it
    v = m[0] | (32'h1 << 23) | (32'h1 << 15);
    do_write(0, v, "R4 R6 enable core2 with reset");
    do_read(0, "R6 reset bit stored 0");
    do_write(0, m[0] | (32'h1 << 24), "R4 enable core3");
    // R5 power-off core 1
    do_write(0, m[0] & ~(32'h1 << 22), "R5 disable core1");
    // R7 reset core 0 and core 2 (enable unchanged)
    do_write(0, m[0] | (32'h1 << 13) | (32'h1 << 15), "R7 reset core0 core2");
    do_read(0, "R7 reset bits read 0");
    // R8 peripheral resets
    do_write(0, m[0] | (32'h1 << 3) | (32'h1 << 12), "R8 periph resets");
    do_read(0, "R8 periph bits read 0");
    // R9 other bits change, no requests
    do_write(0, m[0] ^ 32'h8000_0420, "R9 plain ctrl bits");
    do_write(0, m[0], "R9 rewrite same value");
    do_read(0, "R9 ctrl readback");

    // Random mix
    for (int n = 0; n < 400; n++) begin
      int op;
      op = int'($urandom % 8);
      case (op)
        0, 1, 2: do_write(0, $urandom, "R4 R5 R6 R7 R8 R9 random ctrl");
        3: do_write(8 + int'($urandom % 10), $urandom, "R2 random gpr");
        4: do_write(1 + int'($urandom % 7), $urandom, "R2 random word");
        5: do_read(int'($urandom % 18), "R2 random read");
        6: begin
          if ($urandom % 2 == 0) do_write(18 + int'($urandom % 1006), $urandom, "R3 random oob write");
          else do_read(18 + int'($urandom % 1006), "R3 random oob read");
        end
        default: do_rw(1 + int'($urandom % 17), $urandom);
      endcase
    end
    read_all("R2 R3 final contents");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule